// File: doc/BRIEF.md
# Wait-State Flash Line Reader

This block sits between a simple request/ready bus and a synchronous on-chip flash array. It takes a byte address and a transfer size of 8, 16 or 32 bits. It fetches the whole 128-bit line that holds the address. It then returns the requested bytes, zero-extended to 32 bits, and raises ready for one cycle. The requester keeps its request asserted and is stalled until that ready pulse.

The block has no timer of its own, so it cannot know when the array data is stable. Software programs a 4-bit wait-state register. For the number of cycles that register sets, the controller holds the array enable and the line address steady. It then captures the line. Requests that are not aligned, and requests with the reserved size code, get an error response at once and never touch the array.

Top module: `flash_rd_port`

## Requirements
- R1: While rst_ni is low, rsp_ready_o, rsp_err_o and flash_en_o are 0 and rsp_data_o is all zeros.
- R2: For an accepted aligned request, flash_en_o is high for exactly ws+1 consecutive cycles, where ws is the wait-state value. During that time flash_addr_o equals req_addr_i[15:4] and does not change.
- R3: The line is captured at the clock edge that ends the last enabled cycle. If the request is accepted at edge E0, ready is high in the cycle after edge E0+ws+1.
- R4: Size code 0 returns the byte at the address, code 1 the halfword and code 2 the word. req_addr_i[3:0] selects the starting byte lane of the line, where lane k is flash_line_i[8k+7:8k]. Bytes are packed little-endian, with the lowest address in bits [7:0], and the upper bits are zero-filled.
- R5: rsp_ready_o is high for exactly one cycle per request. After ready drops, the block accepts no new request until req_valid_i is sampled high again in the idle state.
- R6: ws_we_i loads ws_wdata_i into the wait-state register at the clock edge. The reset value is 15. The value in force at the accepting edge governs the whole access, and a write made during an access applies only from the next request.
- R7: A halfword request with req_addr_i[0]=1, or a word request with req_addr_i[1:0]≠0, completes with rsp_ready_o and rsp_err_o high in the cycle right after the accepting edge. rsp_data_o is zero and flash_en_o is never raised.
- R8: Size code 3 is reserved and is answered like a misaligned request (R7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ws_we_i | input | 1 | Wait-state register write strobe |
| ws_wdata_i | input | 4 | Wait-state value to write |
| req_valid_i | input | 1 | Request pending, held until ready |
| req_addr_i | input | 16 | Byte address |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| rsp_ready_o | output | 1 | One-cycle completion pulse |
| rsp_err_o | output | 1 | Error flag, valid with ready |
| rsp_data_o | output | 32 | Zero-extended read data, valid with ready |
| flash_en_o | output | 1 | Array access enable |
| flash_addr_o | output | 12 | Line index presented to the array |
| flash_line_i | input | 128 | Line data returned by the array |

## Verification
The bench counts cycles from the edge that accepts a request. An aligned read must show ready exactly ws+1 cycles after that edge. An error response must show ready in the cycle immediately after it. A run of enable cycles is counted as well, and it must equal ws+1 for an aligned read and zero for an error. The array model in the bench returns the correct line only during the (ws+1)-th enabled cycle and a poison pattern at every other time. A capture that comes early or late, or that uses the wrong line index, therefore shows up as wrong data. Inputs change and outputs are sampled on falling edges, so each check looks at a settled value.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_DONE   = 2'd2
  } rd_state_e;
endpackage

// File: rtl/flash_ws_reg.sv
module flash_ws_reg #(
  parameter int unsigned WS_W     = 4,
  parameter int unsigned WS_RESET = 15
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [WS_W-1:0] wdata_i,
  output logic [WS_W-1:0] ws_o
);
  logic [WS_W-1:0] ws_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ws_q <= WS_W'(WS_RESET);
    else if (we_i) ws_q <= wdata_i;
  end

  assign ws_o = ws_q;
endmodule

// File: rtl/flash_lane_sel.sv
module flash_lane_sel
  import flash_rd_pkg::*;
#(
  parameter int unsigned LINE_W = 128,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = LINE_W / 8,
  localparam int unsigned OFF_W = $clog2(LANES),
  localparam int unsigned BYTES = DATA_W / 8,
  localparam int unsigned CNT_W = $clog2(BYTES) + 1
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic [OFF_W-1:0]  off_i,
  input  xfer_size_e        size_i,
  output logic [DATA_W-1:0] data_o
);
  logic [7:0]       lane [LANES];
  logic [CNT_W-1:0] nbytes;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: nbytes = CNT_W'(1);
      SZ_HALF: nbytes = CNT_W'(2);
      default: nbytes = CNT_W'(BYTES);
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = line_i[8*g +: 8];
  end

  // result byte j comes from lane off+j; aligned requests never wrap
  for (genvar j = 0; j < BYTES; j++) begin : g_out
    logic [OFF_W-1:0] idx;
    assign idx = off_i + OFF_W'(j);
    assign data_o[8*j +: 8] = (CNT_W'(j) < nbytes) ? lane[idx] : 8'h00;
  end
endmodule

// File: rtl/flash_rd_ctrl.sv
module flash_rd_ctrl
  import flash_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WS_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic [WS_W-1:0]   ws_i,
  input  logic [DATA_W-1:0] lane_data_i,
  output logic              flash_en_o,
  output logic [ADDR_W-1:0] addr_o,
  output xfer_size_e        size_o,
  output logic              rsp_ready_o,
  output logic              rsp_err_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  rd_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  xfer_size_e        size_q;
  logic [WS_W-1:0]   cnt_q;
  logic [DATA_W-1:0] data_q;
  logic              err_q;
  xfer_size_e        req_size;
  logic              bad_req;

  assign req_size = xfer_size_e'(req_size_i);

  always_comb begin
    unique case (req_size)
      SZ_BYTE: bad_req = 1'b0;
      SZ_HALF: bad_req = req_addr_i[0];
      SZ_WORD: bad_req = |req_addr_i[1:0];
      default: bad_req = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      size_q  <= SZ_BYTE;
      cnt_q   <= '0;
      data_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q <= req_addr_i;
          size_q <= req_size;
          if (bad_req) begin
            err_q   <= 1'b1;
            data_q  <= '0;
            state_q <= ST_DONE;
          end else begin
            err_q   <= 1'b0;
            cnt_q   <= ws_i;  // wait count frozen for this access
            state_q <= ST_ACCESS;
          end
        end
        ST_ACCESS: begin
          if (cnt_q == '0) begin
            data_q  <= lane_data_i;
            state_q <= ST_DONE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign flash_en_o  = (state_q == ST_ACCESS);
  assign rsp_ready_o = (state_q == ST_DONE);
  assign rsp_err_o   = rsp_ready_o & err_q;
  assign rsp_data_o  = data_q;
  assign addr_o      = addr_q;
  assign size_o      = size_q;
endmodule

// File: rtl/flash_rd_port.sv
module flash_rd_port
  import flash_rd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned LINE_W   = 128,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned WS_W     = 4,
  parameter int unsigned WS_RESET = 15,
  localparam int unsigned OFF_W   = $clog2(LINE_W / 8),
  localparam int unsigned IDX_W   = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ws_we_i,
  input  logic [WS_W-1:0]   ws_wdata_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  output logic              rsp_ready_o,
  output logic              rsp_err_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              flash_en_o,
  output logic [IDX_W-1:0]  flash_addr_o,
  input  logic [LINE_W-1:0] flash_line_i
);
  logic [WS_W-1:0]   ws;
  logic [ADDR_W-1:0] addr_q;
  xfer_size_e        size_q;
  logic [DATA_W-1:0] lane_data;

  flash_ws_reg #(.WS_W(WS_W), .WS_RESET(WS_RESET)) i_ws_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ws_we_i),
    .wdata_i (ws_wdata_i),
    .ws_o    (ws)
  );

  flash_rd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WS_W(WS_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_addr_i  (req_addr_i),
    .req_size_i  (req_size_i),
    .ws_i        (ws),
    .lane_data_i (lane_data),
    .flash_en_o  (flash_en_o),
    .addr_o      (addr_q),
    .size_o      (size_q),
    .rsp_ready_o (rsp_ready_o),
    .rsp_err_o   (rsp_err_o),
    .rsp_data_o  (rsp_data_o)
  );

  flash_lane_sel #(.LINE_W(LINE_W), .DATA_W(DATA_W)) i_lane_sel (
    .line_i (flash_line_i),
    .off_i  (addr_q[OFF_W-1:0]),
    .size_i (size_q),
    .data_o (lane_data)
  );

  assign flash_addr_o = addr_q[ADDR_W-1:OFF_W];
endmodule

// File: rtl/flash_rd_port_chk.sv
module flash_rd_port_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WS_W   = 4,
  parameter int unsigned IDX_W  = 12,
  parameter int unsigned WS_RESET = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ws_we_i,
  input logic [WS_W-1:0]   ws_wdata_i,
  input logic              rsp_ready_o,
  input logic              rsp_err_o,
  input logic [DATA_W-1:0] rsp_data_o,
  input logic              flash_en_o,
  input logic [IDX_W-1:0]  flash_addr_o
);
  logic [WS_W-1:0] shadow_ws, start_ws;
  logic [WS_W:0]   run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_ws <= WS_W'(WS_RESET);
      start_ws  <= WS_W'(WS_RESET);
      run       <= '0;
    end else begin
      if (ws_we_i) shadow_ws <= ws_wdata_i;
      if (!flash_en_o) start_ws <= shadow_ws;
      run <= flash_en_o ? run + 1'b1 : '0;
    end
  end

  // R5
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_ready_o |=> !rsp_ready_o);

  // R2
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flash_en_o && $past(flash_en_o)) |-> $stable(flash_addr_o));

  // R2
  en_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flash_en_o) |-> (run == ({1'b0, start_ws} + 1'b1)));

  // R3
  ready_after_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flash_en_o) |-> rsp_ready_o);

  // R7
  err_no_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_ready_o && rsp_err_o) |-> (!$past(flash_en_o) && rsp_data_o == '0));

  // R5
  err_only_with_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> rsp_ready_o);
endmodule

bind flash_rd_port flash_rd_port_chk #(
  .DATA_W(DATA_W), .WS_W(WS_W), .IDX_W(IDX_W), .WS_RESET(WS_RESET)
) i_flash_rd_port_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ws_we_i      (ws_we_i),
  .ws_wdata_i   (ws_wdata_i),
  .rsp_ready_o  (rsp_ready_o),
  .rsp_err_o    (rsp_err_o),
  .rsp_data_o   (rsp_data_o),
  .flash_en_o   (flash_en_o),
  .flash_addr_o (flash_addr_o)
);

// File: tb/test_flash_rd_port.sv
`timescale 1ns/1ps
module test_flash_rd_port;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         ws_we = 1'b0;
  logic [3:0]   ws_wdata = '0;
  logic         req_valid = 1'b0;
  logic [15:0]  req_addr = '0;
  logic [1:0]   req_size = '0;
  logic         rsp_ready, rsp_err, flash_en;
  logic [31:0]  rsp_data;
  logic [11:0]  flash_addr;
  logic [127:0] flash_line;

  int checks = 0;
  int errors = 0;
  int exp_ws = 15;
  int en_run = 0;
  int en_total = 0;

  always #2.5 clk = ~clk;

  flash_rd_port i_flash_rd_port (
    .clk_i(clk), .rst_ni(rst_ni), .ws_we_i(ws_we), .ws_wdata_i(ws_wdata),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_size_i(req_size),
    .rsp_ready_o(rsp_ready), .rsp_err_o(rsp_err), .rsp_data_o(rsp_data),
    .flash_en_o(flash_en), .flash_addr_o(flash_addr), .flash_line_i(flash_line)
  );

  // array byte at address a is a[7:0] ^ a[15:8]
  function automatic logic [127:0] line_of(input logic [11:0] idx);
    logic [127:0] l;
    for (int k = 0; k < 16; k++) begin
      logic [15:0] a;
      a = {idx, 4'(k)};
      l[8*k +: 8] = a[7:0] ^ a[15:8];
    end
    return l;
  endfunction

  always @(negedge clk) begin
    en_run   = flash_en ? en_run + 1 : 0;
    en_total = flash_en ? en_total + 1 : en_total;
  end

  // correct line only in the last wait cycle, poison otherwise
  assign flash_line = (flash_en && en_run == exp_ws + 1) ? line_of(flash_addr) : {16{8'hE5}};

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic run_req(input int ws, input logic [1:0] sz, input logic [15:0] ad,
                         input logic e_err, input logic [31:0] e_dat, input string rq,
                         input bit mid_wr, input logic [3:0] mid_val);
    int lat, exp_lat;
    exp_ws = ws;
    @(negedge clk);
    req_valid = 1'b1; req_addr = ad; req_size = sz;
    @(posedge clk);
    en_total = 0;
    @(negedge clk);
    lat = 0;
    if (mid_wr) begin ws_we = 1'b1; ws_wdata = mid_val; end
    while (!rsp_ready && lat < 40) begin
      @(posedge clk); @(negedge clk);
      ws_we = 1'b0;
      lat++;
    end
    ws_we = 1'b0;
    exp_lat = e_err ? 0 : ws + 1;
    chk(rsp_data == e_dat, rq, "data", rsp_data, e_dat);
    chk(rsp_err == e_err, e_err ? rq : "R7", "err", 32'(rsp_err), 32'(e_err));
    chk(lat == exp_lat, e_err ? "R7" : "R3", "latency", 32'(lat), 32'(exp_lat));
    chk(en_total == exp_lat, "R2", "enable cycles", 32'(en_total), 32'(exp_lat));
    req_valid = 1'b0;
    @(negedge clk);
    chk(!rsp_ready, "R5", "ready pulse width", 32'(rsp_ready), 32'(0));
  endtask

  task automatic write_ws(input logic [3:0] v);
    @(negedge clk);
    ws_we = 1'b1; ws_wdata = v;
    @(negedge clk);
    ws_we = 1'b0;
  endtask

  // {ws, size, addr, err, data}
  localparam int NV = 10;
  localparam logic [54:0] VEC [NV] = '{
    {4'd0,  2'd0, 16'h1203, 1'b0, 32'h0000_0011},
    {4'd3,  2'd1, 16'h0A06, 1'b0, 32'h0000_0D0C},
    {4'd7,  2'd2, 16'h340C, 1'b0, 32'h3B3A_3938},
    {4'd15, 2'd2, 16'hFF00, 1'b0, 32'hFCFD_FEFF},
    {4'd1,  2'd0, 16'h000F, 1'b0, 32'h0000_000F},
    {4'd2,  2'd1, 16'h560E, 1'b0, 32'h0000_5958},
    {4'd0,  2'd1, 16'h1001, 1'b1, 32'h0000_0000},
    {4'd4,  2'd2, 16'h2002, 1'b1, 32'h0000_0000},
    {4'd2,  2'd3, 16'h3000, 1'b1, 32'h0000_0000},
    {4'd5,  2'd2, 16'h8080, 1'b0, 32'h0302_0100}
  };

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!rsp_ready && !rsp_err && !flash_en && rsp_data == '0, "R1", "reset outputs",
        {29'd0, rsp_ready, rsp_err, flash_en} | rsp_data, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R6 reset wait-state value is 15
    run_req(15, 2'd2, 16'h340C, 1'b0, 32'h3B3A_3938, "R6", 1'b0, 4'd0);

    // R4 R7 R8 table
    for (int i = 0; i < NV; i++) begin
      logic [54:0] v;
      v = VEC[i];
      write_ws(v[54:51]);
      run_req(int'(v[54:51]), v[50:49], v[48:33], v[32], v[31:0],
              v[32] ? (v[50:49] == 2'd3 ? "R8" : "R7") : "R4", 1'b0, 4'd0);
    end

    // R6 write during access applies to next request only
    write_ws(4'd2);
    run_req(2, 2'd1, 16'h0A06, 1'b0, 32'h0000_0D0C, "R6", 1'b1, 4'd9);
    run_req(9, 2'd0, 16'h1203, 1'b0, 32'h0000_0011, "R6", 1'b0, 4'd0);

    // R5 no spurious response while idle
    repeat (3) @(negedge clk);
    chk(!rsp_ready && !flash_en, "R5", "idle quiet",
        {30'd0, rsp_ready, flash_en}, 32'd0);

    finish_run();
  end
endmodule